// File: doc/BRIEF.md
# Serial Adapter Register and Interrupt Core

This block is the processor-facing half of a two-register asynchronous serial adapter. One select bit picks between the control/status location and the data location. The block keeps the receive buffer, the transmit buffer, the status flags, the interrupt-enable and request-to-send state, and the modem-line tracking for clear-to-send and carrier-detect. It drives one active-high interrupt request.

On the line side the block works in whole bytes. A shifter delivers each received byte on a valid strobe, together with its framing and parity error flags. The block offers a pending transmit byte with a valid/ready handshake, and only while clear-to-send is active. A loss of carrier is caught in a latch. The latch freezes the carrier status bit and can raise a receive-class interrupt. A read of the data register releases it. Bit timing, baud generation and vector routing are left to neighbouring blocks.

Top module: `acia_core`

## Requirements
- R1: Status layout: bit 0 receive-full, bit 1 transmit-empty, bit 2 carrier (1 = inactive), bit 3 clear-to-send (1 = inactive), bit 4 overrun, bit 5 framing error, bit 6 parity error, bit 7 interrupt. While reset is held the status reads 0x0C, `irq` is 0, `tx_valid` is 0 and `rts_n` is 1.
- R2: A control write whose bits 1:0 are not 3 sets the receive-interrupt enable from bit 7. It sets the transmit-interrupt enable only when bits 6:5 equal 1. It drives `rts_n` high only when bits 6:5 equal 2.
- R3: A control write with bits 1:0 equal to 3 clears every status bit except clear-to-send and carrier. It zeroes the receive buffer, drops a pending transmit byte, clears both interrupt enables and the carrier latch, and drives `rts_n` high.
- R4: An arriving byte is stored and sets receive-full. It takes framing and parity error from the flags that arrive with it. It sets overrun if receive-full was already set and clears overrun otherwise.
- R5: A data read returns the receive buffer. It clears receive-full, framing error, overrun, parity error and the interrupt bit, and it releases the carrier latch.
- R6: A data write loads the transmit buffer, clears transmit-empty and the interrupt bit, and marks a byte pending.
- R7: A pending byte is offered on `tx_valid` only while the registered clear-to-send is active (low). It is handed over when `tx_ready` is high. Transmit-empty rises one cycle after the hand-over, and the hand-over raises an interrupt if transmit interrupts are enabled.
- R8: While the carrier latch is clear, status bit 2 follows `dcd_n`. A change of that bit to inactive sets the latch, which freezes the bit, and raises an interrupt if receive interrupts are enabled.
- R9: A raised interrupt sets the status interrupt bit and `irq` only while `int_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Register access strobe, one cycle per access |
| rs | input | 1 | Register select: 0 control/status, 1 data |
| wr | input | 1 | 1 write, 0 read |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for the selected register |
| int_en | input | 1 | Global interrupt enable |
| irq | output | 1 | Interrupt request, active high |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | DATA_W | Received byte |
| rx_frm_err | input | 1 | Framing error of the received byte |
| rx_par_err | input | 1 | Parity error of the received byte |
| tx_byte | output | DATA_W | Byte offered to the line |
| tx_valid | output | 1 | Transmit byte offered |
| tx_ready | input | 1 | Line side accepts the byte |
| cts_n | input | 1 | Clear-to-send, active low |
| dcd_n | input | 1 | Carrier detect, active low |
| rts_n | output | 1 | Request-to-send, active low |

## Verification
Every result is registered once. An access, received byte or line change shows its effect on the status, `irq`, `rts_n` and `tx_valid` after the next rising edge. Two results take one edge more: `tx_valid` follows a clear-to-send change one edge later, because the line is first captured in status. Transmit-empty returns one edge after the hand-over. Data read values come straight from the registers, so the bench samples them before the edge that performs the read. The bench drives on falling edges and checks at the falling edge that follows the edge where each result is due.

// File: rtl/acia_pkg.sv
package acia_pkg;
    localparam int ST_RDRF = 0;
    localparam int ST_TDRE = 1;
    localparam int ST_DCD  = 2;
    localparam int ST_CTS  = 3;
    localparam int ST_OVRN = 4;
    localparam int ST_FE   = 5;
    localparam int ST_PE   = 6;
    localparam int ST_IRQ  = 7;
    localparam int STAT_W  = 8;

    localparam logic [1:0] DIV_MRESET   = 2'b11;
    localparam logic [1:0] TXC_RTSL_TIE = 2'b01;
    localparam logic [1:0] TXC_RTSH     = 2'b10;
    localparam int CTL_RIE_BIT  = 7;
    localparam int CTL_TXC_LSB  = 5;
endpackage

// File: rtl/acia_ctrl_reg.sv
module acia_ctrl_reg
    import acia_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              mreset,
    output logic              rie,
    output logic              tie,
    output logic              rts_n
);
    typedef struct packed {
        logic rie;
        logic tie;
        logic rts_n;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic [1:0] txc;

    always_comb begin
        txc    = wdata[CTL_TXC_LSB +: 2];
        mreset = ctl_wr && (wdata[1:0] == DIV_MRESET);
        ctl_d  = ctl_q;
        if (mreset) begin
            ctl_d.rie   = 1'b0;
            ctl_d.tie   = 1'b0;
            ctl_d.rts_n = 1'b1;
        end else if (ctl_wr) begin
            ctl_d.rie   = wdata[CTL_RIE_BIT];
            ctl_d.tie   = (txc == TXC_RTSL_TIE);
            ctl_d.rts_n = (txc == TXC_RTSH);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{rie: 1'b0, tie: 1'b0, rts_n: 1'b1};
        else        ctl_q <= ctl_d;
    end

    assign rie   = ctl_q.rie;
    assign tie   = ctl_q.tie;
    assign rts_n = ctl_q.rts_n;
endmodule

// File: rtl/acia_tx_buf.sv
module acia_tx_buf #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              mreset,
    input  logic              cts_act,
    input  logic              tx_ready,
    output logic [DATA_W-1:0] tx_byte,
    output logic              tx_valid,
    output logic              tdre,
    output logic              tx_done
);
    typedef struct packed {
        logic [DATA_W-1:0] buf_b;
        logic              pend;
        logic              tdre;
    } tx_t;

    tx_t tx_d, tx_q;

    always_comb begin
        tx_valid = tx_q.pend && cts_act;
        tx_done  = tx_valid && tx_ready;
        tx_d     = tx_q;
        if (!tx_q.pend) tx_d.tdre = 1'b1;
        if (tx_done)    tx_d.pend = 1'b0;
        if (data_wr) begin
            tx_d.buf_b = wdata;
            tx_d.pend  = 1'b1;
            tx_d.tdre  = 1'b0;
        end
        if (mreset) begin
            tx_d.pend = 1'b0;
            tx_d.tdre = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tx_q <= '0;
        else        tx_q <= tx_d;
    end

    assign tx_byte = tx_q.buf_b;
    assign tdre    = tx_q.tdre;
endmodule

// File: rtl/acia_rx_stat.sv
module acia_rx_stat #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_rd,
    input  logic              mreset,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              rx_frm_err,
    input  logic              rx_par_err,
    input  logic              cts_n,
    input  logic              dcd_n,
    output logic [DATA_W-1:0] rxb,
    output logic              rdrf,
    output logic              ovrn,
    output logic              fe,
    output logic              pe,
    output logic              dcd_bit,
    output logic              cts_bit,
    output logic              rx_event,
    output logic              dcd_event
);
    typedef struct packed {
        logic [DATA_W-1:0] rxb;
        logic              rdrf;
        logic              ovrn;
        logic              fe;
        logic              pe;
        logic              dcd;
        logic              cts;
        logic              latch;
    } rx_t;

    rx_t rx_d, rx_q;

    always_comb begin
        rx_d      = rx_q;
        rx_event  = rx_valid;
        dcd_event = 1'b0;
        rx_d.cts  = cts_n;

        if (!rx_q.latch) begin
            rx_d.dcd = dcd_n;
            if (dcd_n && !rx_q.dcd) begin
                rx_d.latch = 1'b1;
                dcd_event  = 1'b1;
            end
        end

        if (data_rd) begin
            rx_d.rdrf  = 1'b0;
            rx_d.fe    = 1'b0;
            rx_d.ovrn  = 1'b0;
            rx_d.pe    = 1'b0;
            rx_d.latch = 1'b0;
        end
        if (mreset) begin
            rx_d.rxb   = '0;
            rx_d.rdrf  = 1'b0;
            rx_d.fe    = 1'b0;
            rx_d.ovrn  = 1'b0;
            rx_d.pe    = 1'b0;
            rx_d.latch = 1'b0;
        end
        if (rx_valid) begin
            rx_d.rxb  = rx_byte;
            rx_d.ovrn = rx_q.rdrf;
            rx_d.rdrf = 1'b1;
            rx_d.fe   = rx_frm_err;
            rx_d.pe   = rx_par_err;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q     <= '0;
            rx_q.dcd <= 1'b1;
            rx_q.cts <= 1'b1;
        end else begin
            rx_q <= rx_d;
        end
    end

    assign rxb     = rx_q.rxb;
    assign rdrf    = rx_q.rdrf;
    assign ovrn    = rx_q.ovrn;
    assign fe      = rx_q.fe;
    assign pe      = rx_q.pe;
    assign dcd_bit = rx_q.dcd;
    assign cts_bit = rx_q.cts;
endmodule

// File: rtl/acia_irq.sv
module acia_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic raise,
    input  logic int_en,
    output logic irq
);
    typedef struct packed {
        logic req;
    } irq_t;

    irq_t irq_d, irq_q;

    always_comb begin
        irq_d = irq_q;
        if (clr)             irq_d.req = 1'b0;
        if (raise && int_en) irq_d.req = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= irq_d;
    end

    assign irq = irq_q.req;
endmodule

// File: rtl/acia_core.sv
module acia_core
    import acia_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              rs,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              int_en,
    output logic              irq,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              rx_frm_err,
    input  logic              rx_par_err,
    output logic [DATA_W-1:0] tx_byte,
    output logic              tx_valid,
    input  logic              tx_ready,
    input  logic              cts_n,
    input  logic              dcd_n,
    output logic              rts_n
);
    logic ctl_wr, data_wr, data_rd, mreset;
    logic rie, tie, tdre, tx_done;
    logic rdrf, ovrn, fe, pe, dcd_bit, cts_bit, rx_event, dcd_event;
    logic raise, irq_clr;
    logic [DATA_W-1:0] rxb;
    logic [STAT_W-1:0] stat;

    assign ctl_wr  = cs && wr && !rs;
    assign data_wr = cs && wr && rs;
    assign data_rd = cs && !wr && rs;

    acia_ctrl_reg #(.DATA_W(DATA_W)) u_ctl (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .wdata(wdata),
        .mreset(mreset), .rie(rie), .tie(tie), .rts_n(rts_n)
    );

    acia_tx_buf #(.DATA_W(DATA_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .wdata(wdata),
        .mreset(mreset), .cts_act(!cts_bit), .tx_ready(tx_ready),
        .tx_byte(tx_byte), .tx_valid(tx_valid), .tdre(tdre), .tx_done(tx_done)
    );

    acia_rx_stat #(.DATA_W(DATA_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .data_rd(data_rd), .mreset(mreset),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_frm_err(rx_frm_err),
        .rx_par_err(rx_par_err), .cts_n(cts_n), .dcd_n(dcd_n),
        .rxb(rxb), .rdrf(rdrf), .ovrn(ovrn), .fe(fe), .pe(pe),
        .dcd_bit(dcd_bit), .cts_bit(cts_bit),
        .rx_event(rx_event), .dcd_event(dcd_event)
    );

    assign raise   = (rie && (rx_event || dcd_event)) || (tie && tx_done);
    assign irq_clr = data_wr || data_rd || mreset;

    acia_irq u_irq (
        .clk(clk), .rst_n(rst_n), .clr(irq_clr), .raise(raise),
        .int_en(int_en), .irq(irq)
    );

    always_comb begin
        stat          = '0;
        stat[ST_RDRF] = rdrf;
        stat[ST_TDRE] = tdre;
        stat[ST_DCD]  = dcd_bit;
        stat[ST_CTS]  = cts_bit;
        stat[ST_OVRN] = ovrn;
        stat[ST_FE]   = fe;
        stat[ST_PE]   = pe;
        stat[ST_IRQ]  = irq;
        rdata         = '0;
        if (rs) rdata = rxb;
        else    rdata[STAT_W-1:0] = stat;
    end
endmodule

// File: rtl/acia_core_chk.sv
module acia_core_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs,
    input logic              rs,
    input logic              wr,
    input logic [DATA_W-1:0] wdata,
    input logic              int_en,
    input logic              irq,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic              cts_n,
    input logic              rts_n
);
    // R7: nothing is offered unless clear-to-send was active one edge earlier
    a_r7_hold_without_cts: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> !$past(cts_n));

    // R7: a hand-over with no new data write leaves nothing offered
    a_r7_single_handover: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && !(cs && wr && rs)) |=> !tx_valid);

    // R9: a new request needs the global enable in the cycle it was raised
    a_r9_gated_request: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(int_en));

    // R5 / R6 / R3: the request drops only after a data access or master reset
    a_r5_irq_clear_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(cs && (rs || (wr && wdata[1:0] == 2'b11))));

    // R3: master reset leaves request-to-send inactive
    a_r3_rts_after_mreset: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && wr && !rs && wdata[1:0] == 2'b11) |=> rts_n);
endmodule

bind acia_core acia_core_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs(cs), .rs(rs), .wr(wr), .wdata(wdata),
    .int_en(int_en), .irq(irq), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .cts_n(cts_n), .rts_n(rts_n)
);

// File: tb/sim_acia_core.sv
module sim_acia_core;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 0, rs = 0, wr = 0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic int_en = 1'b1;
    logic irq;
    logic rx_valid = 0;
    logic [DW-1:0] rx_byte = '0;
    logic rx_frm_err = 0, rx_par_err = 0;
    logic [DW-1:0] tx_byte;
    logic tx_valid;
    logic tx_ready = 0;
    logic cts_n = 1, dcd_n = 1;
    logic rts_n;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    acia_core #(.DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .cs(cs), .rs(rs), .wr(wr), .wdata(wdata),
        .rdata(rdata), .int_en(int_en), .irq(irq), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .rx_frm_err(rx_frm_err), .rx_par_err(rx_par_err),
        .tx_byte(tx_byte), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .cts_n(cts_n), .dcd_n(dcd_n), .rts_n(rts_n)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one access across one rising edge; read value sampled before that edge
    task automatic bus(input logic sel, input logic w, input logic [DW-1:0] d,
                       output logic [DW-1:0] rd);
        @(negedge clk);
        cs = 1; rs = sel; wr = w; wdata = d;
        #1 rd = rdata;
        @(negedge clk);
        cs = 0; wr = 0;
    endtask

    task automatic status(output logic [DW-1:0] s);
        rs = 0;
        #1 s = rdata;
    endtask

    task automatic rx_push(input logic [DW-1:0] b, input logic f, input logic p);
        @(negedge clk);
        rx_valid = 1; rx_byte = b; rx_frm_err = f; rx_par_err = p;
        @(negedge clk);
        rx_valid = 0; rx_frm_err = 0; rx_par_err = 0;
    endtask

    task automatic t_reset();
        logic [DW-1:0] s;
        rst_n = 0;
        repeat (2) @(negedge clk);
        status(s);
        check("R1 status in reset", s, 8'h0C);
        check("R1 irq in reset", irq, 0);
        check("R1 rts_n in reset", rts_n, 1);
        check("R1 tx_valid in reset", tx_valid, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);
        status(s);
        check("R1 status idle", s, 8'h0E);
    endtask

    task automatic t_ctrl();
        logic [DW-1:0] r;
        bus(0, 1, 8'h80, r);
        check("R2 rts low for field 0", rts_n, 0);
        bus(0, 1, 8'h40, r);
        check("R2 rts high for field 2", rts_n, 1);
        bus(0, 1, 8'h20, r);
        check("R2 rts low for field 1", rts_n, 0);
    endtask

    task automatic t_rx();
        logic [DW-1:0] r, s;
        bus(0, 1, 8'h80, r);
        rx_push(8'hA5, 0, 0);
        status(s);
        check("R4 first byte status", s, 8'h8F);
        check("R4 irq on arrival", irq, 1);
        rx_push(8'h3C, 1, 0);
        status(s);
        check("R4 overrun and framing", s, 8'hBF);
        bus(1, 0, 8'h00, r);
        check("R5 read returns buffer", r, 8'h3C);
        status(s);
        check("R5 flags cleared by read", s, 8'h0E);
        check("R5 irq cleared by read", irq, 0);
        rx_push(8'h11, 0, 1);
        status(s);
        check("R4 parity flag, no overrun", s, 8'hCF);
        bus(1, 0, 8'h00, r);
    endtask

    task automatic t_gate();
        logic [DW-1:0] r, s;
        int_en = 0;
        rx_push(8'h77, 0, 0);
        status(s);
        check("R9 no irq while disabled", irq, 0);
        check("R9 status bit 7 stays clear", s, 8'h0F);
        bus(1, 0, 8'h00, r);
        int_en = 1;
    endtask

    task automatic t_tx();
        logic [DW-1:0] r, s;
        bus(0, 1, 8'h20, r);
        bus(1, 1, 8'h5A, r);
        status(s);
        check("R6 write clears empty", s, 8'h0C);
        repeat (3) @(negedge clk);
        check("R7 held while cts inactive", tx_valid, 0);
        cts_n = 0;
        @(negedge clk);
        check("R7 offered once cts active", tx_valid, 1);
        check("R7 offered byte", tx_byte, 8'h5A);
        tx_ready = 1;
        @(negedge clk);
        tx_ready = 0;
        status(s);
        check("R7 handed over, irq raised", s, 8'h84);
        check("R7 irq output", irq, 1);
        check("R7 nothing offered after", tx_valid, 0);
        @(negedge clk);
        status(s);
        check("R7 empty one cycle later", s, 8'h86);
        bus(1, 1, 8'h66, r);
        status(s);
        check("R6 write clears irq", s, 8'h04);
        tx_ready = 1;
        @(negedge clk);
        tx_ready = 0;
        cts_n = 1;
        bus(1, 0, 8'h00, r);
    endtask

    task automatic t_mreset();
        logic [DW-1:0] r, s;
        bus(0, 1, 8'h80, r);
        bus(1, 1, 8'h99, r);
        rx_push(8'h42, 1, 0);
        bus(0, 1, 8'h03, r);
        status(s);
        check("R3 status after master reset", s, 8'h0C);
        check("R3 rts inactive", rts_n, 1);
        check("R3 irq cleared", irq, 0);
        bus(1, 0, 8'h00, r);
        check("R3 receive buffer zeroed", r, 8'h00);
        cts_n = 0;
        repeat (3) @(negedge clk);
        check("R3 pending byte dropped", tx_valid, 0);
        rx_push(8'h55, 0, 0);
        check("R3 receive interrupt disabled", irq, 0);
        bus(1, 0, 8'h00, r);
        cts_n = 1;
        @(negedge clk);
    endtask

    task automatic t_dcd();
        logic [DW-1:0] r, s;
        bus(0, 1, 8'h80, r);
        dcd_n = 0;
        @(negedge clk);
        status(s);
        check("R8 carrier follows input", s, 8'h0A);
        dcd_n = 1;
        @(negedge clk);
        status(s);
        check("R8 loss latched with irq", s, 8'h8E);
        dcd_n = 0;
        repeat (2) @(negedge clk);
        status(s);
        check("R8 bit frozen while latched", s, 8'h8E);
        bus(1, 0, 8'h00, r);
        @(negedge clk);
        status(s);
        check("R8 R5 read releases latch", s, 8'h0A);
        dcd_n = 1;
        bus(0, 1, 8'h03, r);
        @(negedge clk);
        dcd_n = 0;
        @(negedge clk);
        dcd_n = 1;
        @(negedge clk);
        check("R8 no irq with receive irq off", irq, 0);
    endtask

    initial begin
        t_reset();
        t_ctrl();
        t_rx();
        t_gate();
        t_tx();
        t_mreset();
        t_dcd();
        finished = 1;
    end

    initial begin
        fork
            wait (finished);
            begin
                repeat (20000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog actual=running expected=done");
            end
        join_any
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule